// File: doc/BRIEF.md
# Phase-Ordered Commit Arbiter

This block decides which of several processor nodes may publish its buffered speculative results. A node that has finished a transaction raises a commit request. With the request it gives a phase number and a flag that says whether the commit must respect phase order. Exactly one node at a time is awarded the shared broadcast medium. It keeps that award until it reports that its whole commit packet has gone out. Nodes then begin their next transaction and request again, so the request and grant loop runs without end.

Ordered requests carry a phase. An ordered request whose phase is ahead of the arbiter's global phase waits. The global phase steps forward one value at a time, and only once nothing at or behind it is still waiting or committing. Because of this, a group of transactions that share a phase works as a barrier for every later phase. Unordered requests skip the phase check entirely. Among eligible requests, a rotating priority that starts just after the last winner prevents starvation.

The controller has two states. `ST_IDLE` means no node holds the medium. `ST_HOLD` means one node is committing. The transition IDLE to HOLD is taken when any request is eligible, and HOLD to IDLE is taken when the holder asserts its done line.

Top module: `commit_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_o` is all zero and `cur_phase_o` is 0.
- R2: `grant_o` never has more than one bit set.
- R3: An eligible request presented in ST_IDLE is granted on the next clock edge, so the grant bit is visible one cycle after the request.
- R4: Once set, a grant bit stays set until that same node asserts its `done_i` bit. `done_i` bits from other nodes have no effect.
- R5: The clock edge that samples the holder's done clears `grant_o`. `grant_o` then stays zero for exactly one cycle, and a pending eligible request is granted at the following edge.
- R6: An ordered request is eligible only when its phase is not later than `cur_phase_o`. "Later" means that (phase - cur_phase) mod 256 lies in 1..127. An equal phase, or an earlier one (difference 128..255), is eligible at once.
- R7: An unordered request (`ordered_i` bit 0) is eligible whatever its phase, and it never causes `cur_phase_o` to move.
- R8: Among eligible requests, the winner is the first index after the last granted index, searching cyclically upward. After reset the search starts at node 0.
- R9: `cur_phase_o` increases by exactly one in a cycle when two conditions hold: no ordered request or ordered holder is at or behind it, and at least one ordered request is later. Otherwise it holds its value.
- R10: All ordered requests that share the current phase are granted before any ordered request of a later phase.
- R11: Phase stepping wraps from 255 to 0, and the comparisons in R6 stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_NODES | Per-node commit request, held until granted |
| ordered_i | input | N_NODES | Per-node flag: 1 = obey phase order |
| phase_i | input | N_NODES*PHASE_W | Per-node phase, node k in bits k*PHASE_W upward |
| done_i | input | N_NODES | Per-node pulse: commit packet fully sent |
| grant_o | output | N_NODES | One-hot commit permission |
| cur_phase_o | output | PHASE_W | Global phase value |

## Verification
The main function is exercised with four kinds of input. A single unordered request checks grant latency and shows that stray done pulses from other nodes are ignored. All nodes requesting together separates rotating priority from fixed priority. A mixed set of two same-phase ordered requests and one next-phase request shows whether the barrier holds and whether the phase moves only after both commits. A chain of far-ahead and behind-the-phase requests drives the phase through the 255-to-0 wrap. It also separates the arithmetic that respects the wrap from a plain magnitude comparison.

// File: rtl/commit_arb_pkg.sv
package commit_arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/commit_rr_picker.sv
module commit_rr_picker #(
    parameter int N_NODES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_NODES-1:0] cand_i,
    input  logic [IDX_W-1:0]   last_i,
    output logic [N_NODES-1:0] pick_o,
    output logic [IDX_W-1:0]   pick_idx_o,
    output logic               any_o
);

    // Search starts one position after the previous winner and wraps.
    always_comb begin
        logic found;
        found      = 1'b0;
        pick_o     = '0;
        pick_idx_o = '0;
        for (int k = 1; k <= N_NODES; k++) begin
            int j;
            j = (int'(last_i) + k) % N_NODES;
            if (!found && cand_i[j]) begin
                found      = 1'b1;
                pick_o[j]  = 1'b1;
                pick_idx_o = IDX_W'(j);
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/commit_phase_tracker.sv
module commit_phase_tracker #(
    parameter int N_NODES = 4,
    parameter int PHASE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_NODES-1:0]         req_i,
    input  logic [N_NODES-1:0]         ordered_i,
    input  logic [N_NODES*PHASE_W-1:0] phase_i,
    input  logic                       hold_valid_i,
    input  logic                       hold_ordered_i,
    input  logic [PHASE_W-1:0]         hold_phase_i,
    output logic [N_NODES-1:0]         eligible_o,
    output logic [PHASE_W-1:0]         cur_phase_o
);

    logic [PHASE_W-1:0] cur_q;
    logic [N_NODES-1:0] ahead;
    logic [PHASE_W-1:0] hold_diff;
    logic               hold_blocks;
    logic               blocking;
    logic               waiting;
    logic               advance;

    // Wrap-aware "ahead of global phase": difference nonzero, top bit clear.
    for (genvar g = 0; g < N_NODES; g++) begin : g_cmp
        logic [PHASE_W-1:0] diff;
        assign diff     = phase_i[g*PHASE_W +: PHASE_W] - cur_q;
        assign ahead[g] = (diff != '0) && !diff[PHASE_W-1];
    end

    assign eligible_o  = req_i & (~ordered_i | ~ahead);

    assign hold_diff   = hold_phase_i - cur_q;
    assign hold_blocks = hold_valid_i && hold_ordered_i &&
                         !((hold_diff != '0) && !hold_diff[PHASE_W-1]);

    assign blocking    = (|(req_i & ordered_i & ~ahead)) || hold_blocks;
    assign waiting     = |(req_i & ordered_i & ahead);
    assign advance     = !blocking && waiting;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (advance) begin
            cur_q <= cur_q + PHASE_W'(1);
        end
    end

    assign cur_phase_o = cur_q;

    // R9: phase only ever moves by a single step
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> (cur_q == $past(cur_q) + PHASE_W'(1)));

    // R9: an ordered holder at the current phase freezes the phase
    a_r9_holder_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid_i && hold_ordered_i && (hold_phase_i == cur_q)) |=> $stable(cur_q));

endmodule

// File: rtl/commit_arbiter.sv
module commit_arbiter
    import commit_arb_pkg::*;
#(
    parameter int N_NODES = 4,
    parameter int PHASE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_NODES-1:0]         req_i,
    input  logic [N_NODES-1:0]         ordered_i,
    input  logic [N_NODES*PHASE_W-1:0] phase_i,
    input  logic [N_NODES-1:0]         done_i,
    output logic [N_NODES-1:0]         grant_o,
    output logic [PHASE_W-1:0]         cur_phase_o
);

    localparam int IDX_W = (N_NODES > 1) ? $clog2(N_NODES) : 1;

    arb_state_e           state_q, state_d;
    logic [N_NODES-1:0]   grant_q;
    logic [IDX_W-1:0]     last_q;
    logic                 hold_ordered_q;
    logic [PHASE_W-1:0]   hold_phase_q;

    logic [N_NODES-1:0]   eligible;
    logic [N_NODES-1:0]   pick;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_any;
    logic                 release_seen;
    logic [PHASE_W-1:0]   cur_phase;

    commit_phase_tracker #(
        .N_NODES (N_NODES),
        .PHASE_W (PHASE_W)
    ) phase_i0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req_i),
        .ordered_i      (ordered_i),
        .phase_i        (phase_i),
        .hold_valid_i   (state_q == ST_HOLD),
        .hold_ordered_i (hold_ordered_q),
        .hold_phase_i   (hold_phase_q),
        .eligible_o     (eligible),
        .cur_phase_o    (cur_phase)
    );

    commit_rr_picker #(
        .N_NODES (N_NODES),
        .IDX_W   (IDX_W)
    ) picker_i0 (
        .cand_i     (eligible),
        .last_i     (last_q),
        .pick_o     (pick),
        .pick_idx_o (pick_idx),
        .any_o      (pick_any)
    );

    assign release_seen = |(grant_q & done_i);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE->HOLD on any eligible request, HOLD->IDLE on holder done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pick_any)     state_d = ST_HOLD;
            ST_HOLD: if (release_seen) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Output and holder registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q        <= '0;
            last_q         <= IDX_W'(N_NODES - 1);
            hold_ordered_q <= 1'b0;
            hold_phase_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_any) begin
                        grant_q        <= pick;
                        last_q         <= pick_idx;
                        hold_ordered_q <= ordered_i[pick_idx];
                        hold_phase_q   <= phase_i[int'(pick_idx)*PHASE_W +: PHASE_W];
                    end
                end
                ST_HOLD: begin
                    if (release_seen) begin
                        grant_q <= '0;
                    end
                end
                default: grant_q <= '0;
            endcase
        end
    end

    assign grant_o     = grant_q;
    assign cur_phase_o = cur_phase;

    logic [PHASE_W-1:0] holder_gap;
    assign holder_gap = hold_phase_q - cur_phase;

    // R2: never more than one grant
    a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R3: a fresh grant goes to a node that was requesting
    a_r3_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant_q) |-> |($past(req_i) & grant_q));

    // R4: grant held until holder done
    a_r4_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_q && !release_seen) |=> (grant_q == $past(grant_q)));

    // R5: holder done always leaves a zero-grant cycle
    a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        release_seen |=> (grant_q == '0));

    // R6: an ordered holder is never ahead of the global phase
    a_r6_holder_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_q && hold_ordered_q) |-> !((holder_gap != '0) && !holder_gap[PHASE_W-1]));

endmodule

// File: tb/commit_arbiter_tb_top.sv
`timescale 1ns/1ps
module commit_arbiter_tb_top;

    localparam int N  = 4;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    ordd = '0;
    logic [N-1:0]    done = '0;
    logic [PW-1:0]   ph [N];
    logic [N*PW-1:0] ph_flat;
    logic [N-1:0]    grant;
    logic [PW-1:0]   cur;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int k = 0; k < N; k++) ph_flat[k*PW +: PW] = ph[k];
    end

    commit_arbiter #(.N_NODES(N), .PHASE_W(PW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .ordered_i   (ordd),
        .phase_i     (ph_flat),
        .done_i      (done),
        .grant_o     (grant),
        .cur_phase_o (cur)
    );

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_grant(input int node, input int maxc, input string tag);
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            if (grant != '0) break;
        end
        expect_eq({tag, " R2 onehot"}, $countones(grant), 1);
        expect_eq({tag, " grant"}, grant, 32'(1) << node);
    endtask

    task automatic release_node(input int node, input string tag);
        req[node]  = 1'b0;
        done[node] = 1'b1;
        @(negedge clk);
        done[node] = 1'b0;
        expect_eq({tag, " R5 gap"}, grant, 0);
    endtask

    task automatic t_reset();
        for (int k = 0; k < N; k++) ph[k] = '0;
        repeat (3) @(negedge clk);
        expect_eq("R1 grant in reset", grant, 0);
        expect_eq("R1 phase in reset", cur, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R1 grant after reset", grant, 0);
        expect_eq("R1 phase after reset", cur, 0);
    endtask

    task automatic t_latency_hold();
        ordd[2] = 1'b0; ph[2] = 8'd0; req[2] = 1'b1;
        wait_grant(2, 1, "R3 one-cycle latency");
        done[1] = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            expect_eq("R4 foreign done ignored", grant, 4);
        end
        done[1] = 1'b0;
        @(negedge clk);
        expect_eq("R4 held without done", grant, 4);
        release_node(2, "R5 single");
    endtask

    task automatic t_round_robin();
        ordd = '0;
        req  = '1;
        wait_grant(3, 1, "R8 first after 2");
        release_node(3, "R8");
        wait_grant(0, 1, "R8 wrap to 0");
        release_node(0, "R8");
        wait_grant(1, 1, "R8 then 1");
        release_node(1, "R8");
        wait_grant(2, 1, "R8 then 2");
        release_node(2, "R8");
        expect_eq("R7 unordered leaves phase", cur, 0);
    endtask

    task automatic t_unordered_far();
        ordd[1] = 1'b0; ph[1] = 8'd77; req[1] = 1'b1;
        wait_grant(1, 1, "R7 unordered far phase");
        expect_eq("R7 phase unchanged", cur, 0);
        release_node(1, "R7");
    endtask

    task automatic t_barrier();
        ph[0] = 8'd0; ph[1] = 8'd0; ph[3] = 8'd1;
        ordd[0] = 1'b1; ordd[1] = 1'b1; ordd[3] = 1'b1;
        req[0] = 1'b1; req[1] = 1'b1; req[3] = 1'b1;
        wait_grant(0, 1, "R10 same phase first");
        expect_eq("R9 phase held by pending", cur, 0);
        release_node(0, "R10");
        wait_grant(1, 1, "R10 same phase second");
        expect_eq("R9 phase held by holder", cur, 0);
        release_node(1, "R10");
        wait_grant(3, 4, "R10 later phase last");
        expect_eq("R9 phase stepped once", cur, 1);
        release_node(3, "R10");
    endtask

    task automatic t_phase_gate();
        ordd[2] = 1'b1; ph[2] = 8'd250; req[2] = 1'b1;
        wait_grant(2, 1, "R6 behind phase eligible");
        expect_eq("R6 phase kept", cur, 1);
        release_node(2, "R6");
        ordd[0] = 1'b1; ph[0] = 8'd3; req[0] = 1'b1;
        @(negedge clk);
        expect_eq("R6 ahead held back", grant, 0);
        expect_eq("R9 stepping", cur, 2);
        wait_grant(0, 3, "R6 granted at phase");
        expect_eq("R9 reached 3", cur, 3);
        release_node(0, "R6");
    endtask

    task automatic t_wrap();
        ordd[1] = 1'b1; ph[1] = 8'd100; req[1] = 1'b1;
        wait_grant(1, 120, "R11 climb 100");
        expect_eq("R11 phase 100", cur, 100);
        release_node(1, "R11");
        ph[1] = 8'd200; req[1] = 1'b1;
        wait_grant(1, 120, "R11 climb 200");
        expect_eq("R11 phase 200", cur, 200);
        release_node(1, "R11");
        ph[1] = 8'd2; req[1] = 1'b1;
        wait_grant(1, 80, "R11 across wrap");
        expect_eq("R11 phase 2 after wrap", cur, 2);
        release_node(1, "R11");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_latency_hold();
        t_round_robin();
        t_unordered_far();
        t_barrier();
        t_phase_gate();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule